// File: doc/BRIEF.md
# Vertical Active Window Generator

This block derives the vertical component of a video line-qualifier for one field. A vertical sync input marks the start of a field. The block counts line strobes after the rising edge of that sync. It skips a programmed number of lines, then opens a window that spans a programmed number of lines. Both numbers are in raw input lines, before any scaling is applied.

Inside the window a line-dropping scaler keeps one line in every N. N is selected by a 16-bit scale code. Only the kept lines raise the active flag. The block also reports a running count of kept lines for the current field. The programmed values are captured at the sync edge, so software may rewrite them at any point during a field.

Top module: `vwin_gen`

## Requirements
- R1: After reset, `line_act_o` is 0 and `out_cnt_o` is 0. Line strobes that arrive before the first rising edge of `vsync_i` never raise `line_act_o`.
- R2: Only a 0-to-1 transition of `vsync_i`, sampled on the clock, starts a field. Holding `vsync_i` high does not restart the field. A line strobe sampled in the same cycle as that transition is not counted. Line index 0 is the first strobe after it.
- R3: Lines with index below `delay_i` are never active.
- R4: The window covers line indices `delay_i` through `delay_i + active_i - 1`, counted in unscaled lines. When `active_i` is 0, no line in the field is active, and `out_cnt_o` never exceeds the latched `active_i`.
- R5: Scale code 16'h0000 keeps every window line, so the final `out_cnt_o` equals `active_i`.
- R6: Scale code 16'h1A00 keeps window lines `delay_i`, `delay_i+4`, `delay_i+8` and so on. The final `out_cnt_o` is `ceil(active_i/4)`, and `out_cnt_o` grows by at most 1 per cycle.
- R7: Any scale code other than 16'h1A00 behaves as 1:1.
- R8: `delay_i`, `active_i` and `scale_i` are captured only at the starting sync edge. A change made during a field takes effect at the next field.
- R9: A new rising sync edge closes any open window. On the clock edge after the cycle in which it is sampled, `line_act_o` is 0 and `out_cnt_o` is 0.
- R10: `line_act_o` and `out_cnt_o` update on the clock edge that samples a counted strobe. They hold their values until the next counted strobe or sync edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vsync_i | input | 1 | Vertical sync; its rising edge starts a field |
| line_i | input | 1 | One-cycle strobe per input line |
| delay_i | input | DW | Lines to skip before the window opens |
| active_i | input | DW | Window length in unscaled lines |
| scale_i | input | 16 | Vertical scale code |
| line_act_o | output | 1 | Current line is a kept window line |
| out_cnt_o | output | DW | Kept lines so far in this field |

## Verification
The bench sweeps every delay from 0 to 5 and every window length from 0 to 9 under three scale codes: 1:1, 4:1, and an unlisted code. After each strobe it compares both outputs against arithmetic on the line index. The zero-length and zero-delay cases show whether window bounds are inclusive or exclusive. The 4:1 sweep with lengths that are not multiples of 4 shows whether the phase restarts at the first window line and how the final count rounds.

Directed fields cover three further behaviours:
- a sync held high across several strobes, which separates edge from level detection;
- a strobe coincident with the sync edge;
- a register rewrite in mid-field, and a sync that arrives while the window is still open.

// File: rtl/vwin_pkg.sv
package vwin_pkg;
  localparam int unsigned MAX_RATIO = 4;
  localparam int unsigned PW = $clog2(MAX_RATIO);
  localparam logic [15:0] CODE_QUARTER = 16'h1A00;

  typedef logic [PW-1:0] step_t;

  // returns ratio-1; unknown codes fall back to 1:1
  function automatic step_t decode_scale(input logic [15:0] code);
    if (code == CODE_QUARTER) return step_t'(MAX_RATIO - 1);
    return '0;
  endfunction
endpackage

// File: rtl/vwin_sync.sv
module vwin_sync
  import vwin_pkg::*;
#(
  parameter int unsigned DW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vsync_i,
  input  logic [DW-1:0] delay_i,
  input  logic [DW-1:0] active_i,
  input  logic [15:0]   scale_i,
  output logic          rise_o,
  output logic          armed_o,
  output logic [DW-1:0] dly_o,
  output logic [DW-1:0] act_o,
  output step_t         rmax_o
);
  logic vs_q;

  assign rise_o = vsync_i & ~vs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vs_q    <= 1'b0;
      armed_o <= 1'b0;
      dly_o   <= '0;
      act_o   <= '0;
      rmax_o  <= '0;
    end else begin
      vs_q <= vsync_i;
      if (rise_o) begin
        armed_o <= 1'b1;
        dly_o   <= delay_i;
        act_o   <= active_i;
        rmax_o  <= decode_scale(scale_i);
      end
    end
  end

  assert_sample_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise_o |=> ($stable(dly_o) && $stable(act_o) && $stable(rmax_o)));
endmodule

// File: rtl/vwin_line.sv
module vwin_line #(
  parameter int unsigned DW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rise_i,
  input  logic          line_i,
  input  logic          armed_i,
  input  logic [DW-1:0] dly_i,
  input  logic [DW-1:0] act_i,
  output logic          strobe_o,
  output logic          in_win_o
);
  localparam int unsigned CW = DW + 1;

  logic [CW-1:0] ln_q;
  logic [CW-1:0] win_lo;
  logic [CW-1:0] win_hi;

  assign win_lo   = {1'b0, dly_i};
  assign win_hi   = {1'b0, dly_i} + {1'b0, act_i};
  assign strobe_o = line_i & ~rise_i & armed_i;
  assign in_win_o = armed_i && (ln_q >= win_lo) && (ln_q < win_hi);

  // ln_q holds the index of the next strobe; saturates past any window end
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        ln_q <= '0;
    else if (rise_i)                    ln_q <= '0;
    else if (strobe_o && ln_q != '1)    ln_q <= ln_q + 1'b1;
  end

  assert_idx_restart_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |=> (ln_q == '0));
endmodule

// File: rtl/vwin_decim.sv
module vwin_decim
  import vwin_pkg::*;
#(
  parameter int unsigned DW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rise_i,
  input  logic          strobe_i,
  input  logic          in_win_i,
  input  step_t         rmax_i,
  input  logic [DW-1:0] act_i,
  output logic          line_act_o,
  output logic [DW-1:0] out_cnt_o
);
  step_t ph_q;
  logic  keep;

  assign keep = in_win_i && (ph_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q       <= '0;
      line_act_o <= 1'b0;
      out_cnt_o  <= '0;
    end else if (rise_i) begin
      ph_q       <= '0;
      line_act_o <= 1'b0;
      out_cnt_o  <= '0;
    end else if (strobe_i) begin
      line_act_o <= keep;
      out_cnt_o  <= out_cnt_o + DW'(keep);
      if (in_win_i) ph_q <= (ph_q == rmax_i) ? '0 : ph_q + 1'b1;
    end
  end

  assert_cnt_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise_i |=> ((out_cnt_o == $past(out_cnt_o)) || (out_cnt_o == $past(out_cnt_o) + 1'b1)));

  assert_cnt_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_cnt_o <= act_i);
endmodule

// File: rtl/vwin_gen.sv
module vwin_gen
  import vwin_pkg::*;
#(
  parameter int unsigned DW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vsync_i,
  input  logic          line_i,
  input  logic [DW-1:0] delay_i,
  input  logic [DW-1:0] active_i,
  input  logic [15:0]   scale_i,
  output logic          line_act_o,
  output logic [DW-1:0] out_cnt_o
);
  logic          rise;
  logic          armed;
  logic [DW-1:0] dly_q;
  logic [DW-1:0] act_q;
  step_t         rmax_q;
  logic          strobe;
  logic          in_win;

  vwin_sync #(.DW(DW)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .vsync_i  (vsync_i),
    .delay_i  (delay_i),
    .active_i (active_i),
    .scale_i  (scale_i),
    .rise_o   (rise),
    .armed_o  (armed),
    .dly_o    (dly_q),
    .act_o    (act_q),
    .rmax_o   (rmax_q)
  );

  vwin_line #(.DW(DW)) u_line (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rise_i   (rise),
    .line_i   (line_i),
    .armed_i  (armed),
    .dly_i    (dly_q),
    .act_i    (act_q),
    .strobe_o (strobe),
    .in_win_o (in_win)
  );

  vwin_decim #(.DW(DW)) u_decim (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rise_i     (rise),
    .strobe_i   (strobe),
    .in_win_i   (in_win),
    .rmax_i     (rmax_q),
    .act_i      (act_q),
    .line_act_o (line_act_o),
    .out_cnt_o  (out_cnt_o)
  );

  assert_idle_unarmed_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed |-> (!line_act_o && out_cnt_o == '0));

  assert_rise_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> (!line_act_o && out_cnt_o == '0));

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe && !rise) |=> ($stable(line_act_o) && $stable(out_cnt_o)));
endmodule

// File: tb/vwin_gen_bench.sv
`timescale 1ns/1ps
module vwin_gen_bench;
  localparam int DW = 6;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          vsync_i = 1'b0;
  logic          line_i = 1'b0;
  logic [DW-1:0] delay_i = '0;
  logic [DW-1:0] active_i = '0;
  logic [15:0]   scale_i = '0;
  logic          line_act_o;
  logic [DW-1:0] out_cnt_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  vwin_gen #(.DW(DW)) u_vwin_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .vsync_i(vsync_i), .line_i(line_i),
    .delay_i(delay_i), .active_i(active_i), .scale_i(scale_i),
    .line_act_o(line_act_o), .out_cnt_o(out_cnt_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ratio_of(input logic [15:0] code);
    return (code == 16'h1A00) ? 4 : 1;
  endfunction

  function automatic int exp_act(input int k, input int d, input int a, input int r);
    if (k < d || k >= d + a) return 0;
    return ((k - d) % r == 0) ? 1 : 0;
  endfunction

  function automatic int exp_cnt(input int k, input int d, input int a, input int r);
    if (k < d) return 0;
    if (k >= d + a) return (a + r - 1) / r;
    return (k - d) / r + 1;
  endfunction

  task automatic pulse_line();
    @(negedge clk_i) line_i = 1'b1;
    @(negedge clk_i) line_i = 1'b0;
  endtask

  task automatic pulse_vs();
    @(negedge clk_i) vsync_i = 1'b1;
    @(negedge clk_i) vsync_i = 1'b0;
  endtask

  task automatic set_regs(input int d, input int a, input logic [15:0] s);
    delay_i  = DW'(d);
    active_i = DW'(a);
    scale_i  = s;
  endtask

  task automatic run_field(input string req, input int d, input int a, input int r, input int n);
    for (int k = 0; k < n; k++) begin
      pulse_line();
      chk(req, int'(line_act_o), exp_act(k, d, a, r));
      chk(req, int'(out_cnt_o), exp_cnt(k, d, a, r));
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [15:0] codes [3];
    codes[0] = 16'h0000; codes[1] = 16'h1A00; codes[2] = 16'h0001;

    repeat (3) @(negedge clk_i);
    // R1: reset state and strobes before any sync
    chk("R1", int'(line_act_o), 0);
    chk("R1", int'(out_cnt_o), 0);
    rst_ni = 1'b1;
    set_regs(0, 5, 16'h0000);
    for (int k = 0; k < 3; k++) begin
      pulse_line();
      chk("R1", int'(line_act_o), 0);
      chk("R1", int'(out_cnt_o), 0);
    end

    // R3 R4 R5 R6 R7: sweep
    for (int s = 0; s < 3; s++) begin
      for (int d = 0; d < 6; d++) begin
        for (int a = 0; a < 10; a++) begin
          set_regs(d, a, codes[s]);
          pulse_vs();
          chk("R9", int'(out_cnt_o), 0);
          run_field(s == 0 ? "R5" : (s == 1 ? "R6" : "R7"), d, a, ratio_of(codes[s]), d + a + 3);
          chk("R4", int'(out_cnt_o), (a + ratio_of(codes[s]) - 1) / ratio_of(codes[s]));
        end
      end
    end

    // R8: mid-field rewrite applies next field
    set_regs(2, 6, 16'h1A00);
    pulse_vs();
    set_regs(0, 3, 16'h0000);
    run_field("R8", 2, 6, 4, 10);
    pulse_vs();
    run_field("R8", 0, 3, 1, 5);

    // R9: sync inside an open window
    set_regs(1, 9, 16'h0000);
    pulse_vs();
    run_field("R9", 1, 9, 1, 3);
    pulse_vs();
    chk("R9", int'(line_act_o), 0);
    chk("R9", int'(out_cnt_o), 0);

    // R2: level held high does not restart
    set_regs(0, 3, 16'h0000);
    @(negedge clk_i) vsync_i = 1'b1;
    pulse_line();
    chk("R2", int'(out_cnt_o), 1);
    pulse_line();
    chk("R2", int'(out_cnt_o), 2);
    @(negedge clk_i) vsync_i = 1'b0;
    pulse_line();
    chk("R2", int'(out_cnt_o), 3);
    chk("R2", int'(line_act_o), 1);

    // R2: strobe coincident with edge is not counted
    set_regs(0, 2, 16'h0000);
    @(negedge clk_i) begin vsync_i = 1'b1; line_i = 1'b1; end
    @(negedge clk_i) begin vsync_i = 1'b0; line_i = 1'b0; end
    chk("R2", int'(line_act_o), 0);
    chk("R2", int'(out_cnt_o), 0);
    pulse_line();
    chk("R2", int'(line_act_o), 1);
    chk("R2", int'(out_cnt_o), 1);

    // R10: outputs hold between strobes
    repeat (5) @(negedge clk_i);
    chk("R10", int'(line_act_o), 1);
    chk("R10", int'(out_cnt_o), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule